// File: doc/BRIEF.md
# Serial Word Receiver with Daisy-Chain Output

This block is the three-wire serial front end of a dual-channel converter controller. An active-low select frames each transfer. While select is low, every rising edge of the serial clock shifts the serial data bit into a word register, most significant bit first. When select returns high, the block presents the collected word to the command decoder with a single-cycle valid strobe. The top stage of the word register also drives a serial output, so several receivers can be chained by wiring one output to the next data input.

The three pins are sampled by a faster system clock through synchronisers, and edges are detected in that domain. A mode input, which the command decoder sets, chooses the serial clock edge on which the chained output changes. On the falling edge, a bit reappears one full word of clocks after it entered. On the rising edge, it reappears half a clock earlier. A frame longer than one word keeps the most recent bits, and the earlier bits move on down the chain.

Top module: `ser_word_rx`

## Requirements
- R1: After reset, `serOut`, `wordValid` and every bit of `wordOut` are 0.
- R2: While `selN` is low, each rising edge of `sclkIn` shifts `sdIn` into the word register at bit 0. When the frame closes, `wordOut` holds the frame's bits, with the first bit sent at bit `WORD_W-1`.
- R3: While `selN` is high, edges on `sclkIn` and values on `sdIn` do not change the word register or `serOut`.
- R4: Each rising edge of `selN` gives exactly one `wordValid` pulse, one cycle long. `wordOut` changes only in a cycle where `wordValid` is high.
- R5: In a frame with more than `WORD_W` rising clock edges, `wordOut` holds the last `WORD_W` bits shifted in.
- R6: With `edgeRise`=0, `serOut` changes only after a falling `sclkIn` edge inside a frame. It then takes the register's top bit, so a bit that entered on rising edge k leaves on falling edge k+`WORD_W`-1.
- R7: With `edgeRise`=1, `serOut` changes only after a rising `sclkIn` edge inside a frame. It then takes the register's top bit after that shift, half a clock earlier than in R6.
- R8: A frame sent as two bursts, separated by an idle gap with `selN` held low, gives the same word as one continuous burst.
- R9: `wordValid` goes high on the (`SYNC_STAGES`+1)-th system clock edge after `selN` rises at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock pin |
| selN | input | 1 | Active-low frame select pin |
| sdIn | input | 1 | Serial data pin |
| edgeRise | input | 1 | Output edge mode: 0 = falling edge, 1 = rising edge |
| serOut | output | 1 | Chained serial output, the top stage of the word register |
| wordOut | output | WORD_W | Word captured at the close of the last frame |
| wordValid | output | 1 | One-cycle strobe when a frame closes |

## Verification
The bench uses the default build: a 16-bit word and two synchroniser stages. This size makes it practical to run a walking-one pass and an arithmetic word sweep in both output modes. The bench checks the chained output after every serial edge against a model of the register's top bit. It also runs overlong frames of 17 to 24 bits, split bursts, and clock activity while deselected. With a shallow synchroniser, the select-to-strobe latency comes to three system cycles, which the bench counts exactly.

// File: rtl/ser_word_rx_pkg.sv
package ser_word_rx_pkg;
  typedef struct packed {
    logic shiftEn;
    logic outRise;
    logic outFall;
    logic wordDone;
  } rxStrobes_t;
endpackage

// File: rtl/ser_word_rx_sync.sv
module ser_word_rx_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= RESET_VAL;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= RESET_VAL;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/ser_word_rx_ctrl.sv
module ser_word_rx_ctrl
  import ser_word_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkS,
  input  logic       selS,
  input  logic       edgeRise,
  output rxStrobes_t strb
);
  logic sclkPrev;
  logic selPrev;
  logic sclkUp;
  logic sclkDown;
  logic inFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      selPrev  <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      selPrev  <= selS;
    end
  end

  always_comb begin
    sclkUp        = sclkS & ~sclkPrev;
    sclkDown      = ~sclkS & sclkPrev;
    inFrame       = ~selS;
    strb.shiftEn  = sclkUp & inFrame;
    strb.outRise  = sclkUp & inFrame & edgeRise;
    strb.outFall  = sclkDown & inFrame & ~edgeRise;
    strb.wordDone = selS & ~selPrev;
  end
endmodule

// File: rtl/ser_word_rx_dp.sv
module ser_word_rx_dp
  import ser_word_rx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strb,
  input  logic              dataS,
  output logic [WORD_W-1:0] shiftQ,
  output logic              serOut,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  localparam int TOP = WORD_W - 1;

  logic [WORD_W-1:0] shiftNext;

  assign shiftNext = {shiftQ[TOP-1:0], dataS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ    <= '0;
      serOut    <= 1'b0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= strb.wordDone;
      if (strb.shiftEn) shiftQ <= shiftNext;
      if (strb.outRise) serOut <= shiftNext[TOP];
      else if (strb.outFall) serOut <= shiftQ[TOP];
      if (strb.wordDone) wordOut <= shiftQ;
    end
  end
endmodule

// File: rtl/ser_word_rx.sv
module ser_word_rx
  import ser_word_rx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              selN,
  input  logic              sdIn,
  input  logic              edgeRise,
  output logic              serOut,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  localparam int PIN_W = 3;
  localparam logic [PIN_W-1:0] PIN_RST = 3'b010;

  logic [PIN_W-1:0] pinSync;
  logic sclkS;
  logic selS;
  logic dataS;
  logic [WORD_W-1:0] shiftQ;
  rxStrobes_t strb;

  ser_word_rx_sync #(
    .WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_RST)
  ) uSync (
    .clk(clk), .rstN(rstN), .asyncIn({sclkIn, selN, sdIn}), .syncOut(pinSync)
  );

  assign {sclkS, selS, dataS} = pinSync;

  ser_word_rx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sclkS(sclkS), .selS(selS),
    .edgeRise(edgeRise), .strb(strb)
  );

  ser_word_rx_dp #(.WORD_W(WORD_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataS(dataS),
    .shiftQ(shiftQ), .serOut(serOut), .wordOut(wordOut), .wordValid(wordValid)
  );
endmodule

// File: rtl/ser_word_rx_chk.sv
module ser_word_rx_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclkS,
  input logic              selS,
  input logic              edgeRise,
  input logic              serOut,
  input logic              wordValid,
  input logic [WORD_W-1:0] wordOut,
  input logic [WORD_W-1:0] shiftQ
);
  logic sPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sPrev <= 1'b0;
    else       sPrev <= sclkS;
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid); // R4
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordOut) |-> wordValid); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    selS |=> $stable(shiftQ)); // R3
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(serOut) && !$past(edgeRise)) |-> ($past(sPrev) && !$past(sclkS) && !$past(selS))); // R6
  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(serOut) && $past(edgeRise)) |-> (!$past(sPrev) && $past(sclkS) && !$past(selS))); // R7
endmodule

bind ser_word_rx ser_word_rx_chk #(.WORD_W(WORD_W)) uChk (
  .clk(clk), .rstN(rstN), .sclkS(sclkS), .selS(selS), .edgeRise(edgeRise),
  .serOut(serOut), .wordValid(wordValid), .wordOut(wordOut), .shiftQ(shiftQ)
);

// File: tb/tb_ser_word_rx.sv
module tb_ser_word_rx;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 16;
  localparam int SYNC_STAGES = 2;
  localparam int SETTLE = SYNC_STAGES + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0;
  logic selN = 1'b1;
  logic sdIn = 1'b0;
  logic edgeRise = 1'b0;
  logic serOut;
  logic [WORD_W-1:0] wordOut;
  logic wordValid;

  int nChk = 0;
  int nBad = 0;
  logic [WORD_W-1:0] expSr = '0;
  logic expOut = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_word_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .selN(selN), .sdIn(sdIn),
    .edgeRise(edgeRise), .serOut(serOut), .wordOut(wordOut), .wordValid(wordValid)
  );

  task automatic chk(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sdIn = b;
    waitCyc(2);
    sclkIn = 1'b1;
    expSr = {expSr[WORD_W-2:0], b};
    if (edgeRise) expOut = expSr[WORD_W-1];
    waitCyc(SETTLE);
    chk(edgeRise ? "R7 rise" : "R6 rise", {15'd0, serOut}, {15'd0, expOut});
    sclkIn = 1'b0;
    if (!edgeRise) expOut = expSr[WORD_W-1];
    waitCyc(SETTLE);
    chk(edgeRise ? "R7 fall" : "R6 fall", {15'd0, serOut}, {15'd0, expOut});
  endtask

  task automatic beginFrame();
    selN = 1'b0;
    waitCyc(SETTLE);
  endtask

  task automatic endFrame(input string req);
    int cnt;
    selN = 1'b1;
    cnt = 0;
    while (cnt < 20) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (wordValid) break;
    end
    chk("R9 latency", cnt[WORD_W-1:0], SYNC_STAGES + 1);
    chk(req, wordOut, expSr);
    waitCyc(1);
    chk("R4 pulse", {15'd0, wordValid}, 16'd0);
    waitCyc(SETTLE);
  endtask

  task automatic sendWord(input logic [WORD_W-1:0] w, input int nBits, input string req);
    beginFrame();
    for (int i = nBits - 1; i >= 0; i--) sendBit(w[i % WORD_W]);
    endFrame(req);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    waitCyc(3);
    chk("R1 wordOut", wordOut, 16'd0);
    rstN = 1'b1;
    waitCyc(2);
    chk("R1 serOut", {15'd0, serOut}, 16'd0);
    chk("R1 wordValid", {15'd0, wordValid}, 16'd0);

    // R2 R6: walking one and arithmetic sweep, falling-edge output mode
    edgeRise = 1'b0;
    for (int k = 0; k < WORD_W; k++) sendWord(16'd1 << k, WORD_W, "R2 walk");
    for (int k = 0; k < 12; k++) sendWord(16'(k * 16'h3D1 ^ 16'hA5C3), WORD_W, "R2 sweep");

    // R7: rising-edge output mode
    edgeRise = 1'b1;
    for (int k = 0; k < WORD_W; k++) sendWord(~(16'd1 << k), WORD_W, "R7 walk");
    for (int k = 0; k < 12; k++) sendWord(16'(k * 16'h1F7 + 16'h0C35), WORD_W, "R7 sweep");

    // R5: overlong frames in both modes
    for (int n = WORD_W + 1; n <= WORD_W + 8; n++) begin
      edgeRise = n[0];
      sendWord(16'(n * 16'h2B9 ^ 16'h5AA5), n, "R5 overlong");
    end

    // R8: two bursts with a gap inside one frame
    for (int k = 0; k < 4; k++) begin
      logic [WORD_W-1:0] w;
      w = 16'(k * 16'h4E6D + 16'h1234);
      edgeRise = k[0];
      beginFrame();
      for (int i = WORD_W - 1; i >= WORD_W / 2; i--) sendBit(w[i]);
      waitCyc(30);
      for (int i = WORD_W / 2 - 1; i >= 0; i--) sendBit(w[i]);
      endFrame("R8 split");
    end

    // R3: clock and data activity while deselected
    edgeRise = 1'b0;
    sendWord(16'hC3A9, WORD_W, "R2 pre-idle");
    for (int i = 0; i < 6; i++) begin
      sdIn = i[0];
      sclkIn = 1'b1;
      waitCyc(SETTLE);
      chk("R3 idle serOut", {15'd0, serOut}, {15'd0, expOut});
      sclkIn = 1'b0;
      waitCyc(SETTLE);
      chk("R3 idle serOut", {15'd0, serOut}, {15'd0, expOut});
    end
    beginFrame();
    endFrame("R3 idle word");

    finishRun();
  end
endmodule